// File: doc/BRIEF.md
# Self-Correcting Synchronous Decade Counter

This block is a single 4-bit decimal digit counter built on one register of D flip-flops. When enabled, it steps through the codes 0 to 9 with bit weights 8-4-2-1 and wraps from 9 back to 0. On that wrap it raises a carry-out for one cycle. Fixed XOR-form equations produce the next code, and these equations are defined for all sixteen codes. If the register is ever disturbed into one of the six unused codes (10 to 15), it falls back into the decimal range within two enabled clocks. While the code is unused, a combinational error flag is raised.

A synchronous preset input can load any 4-bit code into the register. This preset is the only way to place an unused code from outside the block, so it is the path used to bring about the recovery behaviour. Reset is synchronous and active high. Reset takes priority over preset, and preset takes priority over counting.

Top module: `bcd_decade_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, the count becomes 0 after that edge, whatever `load_en` and `count_en` are.
- R2: When `rst` is 0 and `load_en` is 1 at an edge, the count becomes `load_val` after that edge, for any of the 16 codes, whatever `count_en` is.
- R3: When `rst`, `load_en` and `count_en` are all 0 at an edge, the count keeps its value, including an unused code 10 to 15.
- R4: When counting (`rst` 0, `load_en` 0, `count_en` 1) from a code 0 to 8, the count becomes the code plus one. `digit[3]` weighs 8, `digit[2]` 4, `digit[1]` 2 and `digit[0]` 1.
- R5: When counting from 9, the count becomes 0. `carry` is 1 exactly when the count is 9 and `count_en` is 1, combinationally and in the same cycle.
- R6: `bad_code` is 1 exactly when the count is 10 to 15, and 0 for counts 0 to 9.
- R7: When counting from an unused code, the successors are 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2. Every unused code therefore reaches 0 to 9 within at most two counting edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to count 0 |
| load_en | input | 1 | Synchronous preset strobe |
| load_val | input | 4 | Code loaded when `load_en` is 1 |
| count_en | input | 1 | Advance the count by one step |
| digit | output | 4 | Present count, 8-4-2-1 weighted |
| carry | output | 1 | Count is 9 and counting is enabled |
| bad_code | output | 1 | Present count is an unused code 10 to 15 |

## Verification
The hard situation is the counter sitting in an unused code. Counting from reset never leaves the range 0 to 9, so the recovery paths and the error flag cannot be reached by enabling and resetting alone. The stimulus uses the preset port to place each of the codes 10 to 15 in turn. It then checks the flag and counts forward through the two-step return paths. It also holds an unused code with counting disabled, to show that no correction happens without counting.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

    localparam int DIGIT_W   = 4;
    localparam int MAX_DIGIT = 9;
    localparam int NUM_CODES = 1 << DIGIT_W;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Register action chosen for the coming edge, in priority order
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2,
        ACT_KEEP  = 2'd3
    } reg_act_e;

    // Weighted view of one digit
    typedef struct packed {
        logic w8;
        logic w4;
        logic w2;
        logic w1;
    } bcd_bits_t;

    function automatic bcd_bits_t split_digit(input digit_t d);
        bcd_bits_t b;
        b.w8 = d[3];
        b.w4 = d[2];
        b.w2 = d[1];
        b.w1 = d[0];
        return b;
    endfunction

    function automatic digit_t join_digit(input bcd_bits_t b);
        return {b.w8, b.w4, b.w2, b.w1};
    endfunction

    // XOR-form successor, defined for every code
    function automatic bcd_bits_t step_bits(input bcd_bits_t c);
        bcd_bits_t n;
        n.w1 = ~c.w1;
        n.w2 = c.w2 ^ (c.w1 & ~c.w8);
        n.w4 = c.w4 ^ (c.w1 & c.w2);
        n.w8 = c.w8 ^ ((c.w1 & c.w8) | (c.w1 & c.w2 & c.w4));
        return n;
    endfunction

    // Unused-code detector on the weighted bits
    function automatic logic code_unused(input bcd_bits_t c);
        return (c.w8 & c.w4) | (c.w8 & c.w2);
    endfunction

endpackage

// File: rtl/bcd_act_decode.sv
module bcd_act_decode
    import bcd_ctr_pkg::*;
(
    input  logic     rst,
    input  logic     load_en,
    input  logic     count_en,
    output reg_act_e act
);

    always_comb begin
        if (rst)
            act = ACT_CLEAR;
        else if (load_en)
            act = ACT_LOAD;
        else if (count_en)
            act = ACT_STEP;
        else
            act = ACT_KEEP;
    end

endmodule

// File: rtl/bcd_step_logic.sv
module bcd_step_logic
    import bcd_ctr_pkg::*;
(
    input  digit_t cur,
    output digit_t nxt,
    output logic   unused_code,
    output logic   at_top
);

    bcd_bits_t cur_b;
    bcd_bits_t nxt_b;

    always_comb begin
        cur_b       = split_digit(cur);
        nxt_b       = step_bits(cur_b);
        nxt         = join_digit(nxt_b);
        unused_code = code_unused(cur_b);
        at_top      = (cur == digit_t'(MAX_DIGIT));
    end

endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
    import bcd_ctr_pkg::*;
(
    input  logic     clk,
    input  reg_act_e act,
    input  digit_t   load_val,
    input  digit_t   step_val,
    output digit_t   cur
);

    digit_t cnt_q;
    digit_t cnt_d;

    always_comb begin
        unique case (act)
            ACT_CLEAR: cnt_d = '0;
            ACT_LOAD:  cnt_d = load_val;
            ACT_STEP:  cnt_d = step_val;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cur = cnt_q;

endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_ctr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  logic [3:0] load_val,
    input  logic       count_en,
    output logic [3:0] digit,
    output logic       carry,
    output logic       bad_code
);

    reg_act_e act;
    digit_t   cur;
    digit_t   nxt;
    logic     unused_code;
    logic     at_top;

    bcd_act_decode u_dec (
        .rst      (rst),
        .load_en  (load_en),
        .count_en (count_en),
        .act      (act)
    );

    bcd_step_logic u_step (
        .cur         (cur),
        .nxt         (nxt),
        .unused_code (unused_code),
        .at_top      (at_top)
    );

    bcd_state_reg u_reg (
        .clk      (clk),
        .act      (act),
        .load_val (load_val),
        .step_val (nxt),
        .cur      (cur)
    );

    assign digit    = cur;
    assign carry    = at_top & count_en;
    assign bad_code = unused_code;

endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_en,
    input logic [3:0] load_val,
    input logic       count_en,
    input logic [3:0] digit,
    input logic       carry,
    input logic       bad_code
);

    logic stepping;
    assign stepping = !rst && !load_en && count_en;

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> digit == 4'd0);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && load_en) |=> digit == $past(load_val));

    assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_en && !count_en) |=> $stable(digit));

    assert_inc_R4: assert property (@(posedge clk) disable iff (rst)
        (stepping && digit < 4'd9) |=> digit == $past(digit) + 4'd1);

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (stepping && digit == 4'd9) |=> digit == 4'd0);

    assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
        carry == (count_en && digit == 4'd9));

    assert_flag_R6: assert property (@(posedge clk) disable iff (rst)
        bad_code == (digit > 4'd9));

    assert_odd_back_R7: assert property (@(posedge clk) disable iff (rst)
        (stepping && digit > 4'd9 && digit[0]) |=> digit <= 4'd9);

    assert_even_up_R7: assert property (@(posedge clk) disable iff (rst)
        (stepping && digit > 4'd9 && !digit[0]) |=> digit == $past(digit) + 4'd1);

endmodule

bind bcd_decade_counter bcd_decade_counter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .count_en (count_en),
    .digit    (digit),
    .carry    (carry),
    .bad_code (bad_code)
);

// File: tb/bcd_decade_counter_tb_top.sv
module bcd_decade_counter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [3:0] load_val;
    logic       count_en;
    logic [3:0] digit;
    logic       carry;
    logic       bad_code;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_decade_counter dut_i (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .count_en (count_en),
        .digit    (digit),
        .carry    (carry),
        .bad_code (bad_code)
    );

    // inputs for one edge; co/err expected before the edge, q after it
    typedef struct packed {
        logic       rst;
        logic       ld;
        logic [3:0] lv;
        logic       en;
        logic       co;
        logic       err;
        logic [3:0] q;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd1},   // R4 0->1
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd2},   // R4
        '{1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0,4'd2},   // R3 hold
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd3},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd4},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd5},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd6},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd7},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd8},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0,4'd9},
        '{1'b0,1'b0,4'd0, 1'b1,1'b1,1'b0,4'd0},   // R5 wrap + carry
        '{1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0,4'd0},   // R3
        '{1'b0,1'b1,4'd9, 1'b0,1'b0,1'b0,4'd9},   // R2
        '{1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0,4'd9},   // R5 no carry without enable
        '{1'b1,1'b0,4'd0, 1'b1,1'b1,1'b0,4'd0},   // R1 over enable
        '{1'b0,1'b1,4'd10,1'b0,1'b0,1'b0,4'd10},  // R2 unused code
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd11},  // R7 10->11
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd6},   // R7 11->6
        '{1'b0,1'b1,4'd12,1'b0,1'b0,1'b0,4'd12},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd13},  // R7 12->13
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd4},   // R7 13->4
        '{1'b0,1'b1,4'd14,1'b0,1'b0,1'b0,4'd14},
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd15},  // R7 14->15
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd2},   // R7 15->2
        '{1'b0,1'b1,4'd11,1'b0,1'b0,1'b0,4'd11},
        '{1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1,4'd11},  // R3 illegal held
        '{1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1,4'd6},   // R7
        '{1'b0,1'b1,4'd5, 1'b1,1'b0,1'b0,4'd5},   // R2 over enable
        '{1'b1,1'b1,4'd7, 1'b1,1'b0,1'b0,4'd0},   // R1 over preset
        '{1'b0,1'b1,4'd9, 1'b1,1'b0,1'b0,4'd9},   // R2
        '{1'b0,1'b1,4'd3, 1'b1,1'b1,1'b0,4'd3}    // R5 carry at 9, R2 load wins
    };

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic l, input logic [3:0] v, input logic e);
        @(negedge clk);
        rst = r; load_en = l; load_val = v; count_en = e;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; load_val = '0; count_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1", "reset count", digit, 4'd0);
        check("R6", "reset flag", {3'b0, bad_code}, 4'd0);
        check("R5", "reset carry", {3'b0, carry}, 4'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].rst, VECS[i].ld, VECS[i].lv, VECS[i].en);
            #1;
            check("R5", $sformatf("vec %0d carry", i), {3'b0, carry}, {3'b0, VECS[i].co});
            check("R6", $sformatf("vec %0d flag", i), {3'b0, bad_code}, {3'b0, VECS[i].err});
            @(posedge clk);
            #1;
            check("R4", $sformatf("vec %0d count", i), digit, VECS[i].q);
        end

        // R6: flag for every code, each placed by preset
        for (int c = 0; c < 16; c++) begin
            drive(1'b0, 1'b1, 4'(c), 1'b0);
            @(posedge clk);
            #1;
            check("R2", "preset code", digit, 4'(c));
            check("R6", "flag per code", {3'b0, bad_code}, {3'b0, (c > 9)});
        end

        // R7: each unused code reaches 0..9 within two counting edges
        for (int c = 10; c < 16; c++) begin
            logic [3:0] e1, e2;
            e1 = (c % 2 == 0) ? 4'(c + 1) : ((c == 11) ? 4'd6 : (c == 13) ? 4'd4 : 4'd2);
            e2 = (c == 10) ? 4'd6 : (c == 12) ? 4'd4 : (c == 14) ? 4'd2 : 4'(e1 + 1);
            drive(1'b0, 1'b1, 4'(c), 1'b0);
            drive(1'b0, 1'b0, 4'd0, 1'b1);
            @(posedge clk);
            #1;
            check("R7", $sformatf("first step from %0d", c), digit, e1);
            @(posedge clk);
            #1;
            check("R7", $sformatf("second step from %0d", c), digit, e2);
            check("R7", "back in range", {3'b0, (digit <= 4'd9)}, 4'd1);
        end

        // R5: twenty counting edges from 0 give two carries and end at 0
        drive(1'b1, 1'b0, 4'd0, 1'b0);
        drive(1'b0, 1'b0, 4'd0, 1'b1);
        begin
            int carries = 0;
            for (int k = 0; k < 20; k++) begin
                #1;
                if (carry) carries++;
                @(posedge clk);
                @(negedge clk);
            end
            check("R5", "carry pulses in 20 steps", 4'(carries), 4'd2);
            check("R5", "count after 20 steps", digit, 4'd0);
        end

        // R1: reset from mid count with preset pending
        drive(1'b0, 1'b1, 4'd7, 1'b0);
        drive(1'b1, 1'b1, 4'd4, 1'b1);
        @(posedge clk);
        #1;
        check("R1", "reset mid count", digit, 4'd0);

        finish_run();
    end

endmodule